// File: doc/BRIEF.md
# Self-Correcting Decade Ring Counter

This block counts through ten states held in a five-stage twisted ring and shows the count on ten active-high lines, exactly one of which is high at a time. An active-low carry line is low for the upper five counts. Its rising edge on the wrap from the last count back to the first can clock the next counter in a chain.

The block has two count inputs that gate each other and are sampled on the system clock. A rising edge on the positive count input is counted only while the negative count input is low. A falling edge on the negative count input is counted only while the positive count input is high. Any other change on these inputs leaves the count alone. A master clear forces count zero at once, whatever the count inputs are doing. The clear is released to the ring on the clock, and the first two clock edges after release are ignored. A seed port writes the ring directly, so that any pattern, legal or not, can be placed in it. Steering logic in the ring feedback brings every illegal pattern back into the ten-state cycle.

Top module: `jdc_counter`

## Requirements
- R1: While `mr_i` is high, `dec_o` is 10'b0000000001 and `carry_n_o` is 1. This takes effect at once on assertion, without waiting for a clock edge.
- R2: A rising edge on `tick_p_i` while `tick_n_i` is low advances the count by exactly one.
- R3: A falling edge on `tick_n_i` while `tick_p_i` is high advances the count by exactly one.
- R4: The following leave `dec_o` unchanged: a rising edge of `tick_p_i` while `tick_n_i` is high, a falling edge of `tick_n_i` while `tick_p_i` is low, a falling edge of `tick_p_i`, a rising edge of `tick_n_i`, and steady levels.
- R5: In the legal cycle, exactly one bit of `dec_o` is high. Bit k is high in count k, each advance moves the high bit up by one position, and count 9 wraps to count 0.
- R6: `carry_n_o` is 0 in counts 5 to 9 and 1 in counts 0 to 4, so it rises on the wrap from 9 to 0.
- R7: After any of the 22 illegal ring patterns is seeded, the counter is in the legal cycle within 11 advances. From then on, `dec_o` is one-hot and steps in order.
- R8: With `seed_we_i` high at a clock edge, the ring takes `seed_i`. Ring bit 0 is the stage fed with the inverted top bit. The legal codes for counts 0 to 9 are 00000, 00001, 00011, 00111, 01111, 11111, 11110, 11100, 11000 and 10000, written bit 4 down to bit 0.
- R9: A qualifying edge applied between clock edges shows on `dec_o` after the third rising clock edge that follows it, and not after the second.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| mr_i | input | 1 | Master clear, active high, asynchronous assertion |
| tick_p_i | input | 1 | Count input that acts on its rising edge |
| tick_n_i | input | 1 | Count input that acts on its falling edge |
| seed_we_i | input | 1 | Load strobe for the ring |
| seed_i | input | 5 | Ring pattern to load |
| dec_o | output | 10 | One-hot decoded count |
| carry_n_o | output | 1 | Active-low carry, low in counts 5 to 9 |

## Verification
The count is first driven by long trains of qualifying edges on each count input separately, which shows wrap and carry behaviour over more than two full cycles. It is then driven with edge sequences in which the gating input moves first. These keep apart a design that counts on any edge from one that honours the gating level. Every one of the 22 illegal ring patterns is seeded, and its recovery distance and the following ten-step order are measured, which separates correct steering feedback from a plain twisted ring. The clear is raised between clock edges to show that it does not wait for the clock.

// File: rtl/jdc_pkg.sv
package jdc_pkg;

    localparam int unsigned RING_W_DEF = 5;
    localparam int unsigned SYNC_N_DEF = 2;
    localparam int unsigned HOLD_N_DEF = 2;

    // Sampled view of the two count inputs, this cycle and the one before.
    typedef struct packed {
        logic p_now;
        logic p_was;
        logic n_now;
        logic n_was;
    } tick_view_t;

    // Which of the two qualifying edge cases is present.
    typedef struct packed {
        logic by_rise;
        logic by_fall;
    } tick_hit_t;

    function automatic tick_hit_t classify(input tick_view_t v);
        tick_hit_t h;
        h.by_rise = v.p_now & ~v.p_was & ~v.n_now;
        h.by_fall = v.n_was & ~v.n_now & v.p_now;
        return h;
    endfunction

endpackage

// File: rtl/jdc_edge_sync.sv
module jdc_edge_sync #(
    parameter int unsigned SYNC_N = jdc_pkg::SYNC_N_DEF
) (
    input  logic clk,
    input  logic tick_p_i,
    input  logic tick_n_i,
    output logic adv_o
);
    import jdc_pkg::*;

    localparam int unsigned TOP = SYNC_N - 1;

    logic [SYNC_N-1:0] p_pipe;
    logic [SYNC_N-1:0] n_pipe;
    logic              p_old;
    logic              n_old;
    tick_view_t        view;
    tick_hit_t         hit;

    always_ff @(posedge clk) begin
        p_pipe <= {p_pipe[SYNC_N-2:0], tick_p_i};
        n_pipe <= {n_pipe[SYNC_N-2:0], tick_n_i};
        p_old  <= p_pipe[TOP];
        n_old  <= n_pipe[TOP];
    end

    always_comb begin
        view.p_now = p_pipe[TOP];
        view.p_was = p_old;
        view.n_now = n_pipe[TOP];
        view.n_was = n_old;
        hit        = classify(view);
        adv_o      = hit.by_rise | hit.by_fall;
    end

endmodule

// File: rtl/jdc_rst_hold.sv
module jdc_rst_hold #(
    parameter int unsigned HOLD_N = jdc_pkg::HOLD_N_DEF
) (
    input  logic clk,
    input  logic mr_i,
    output logic hold_o
);
    logic [HOLD_N-1:0] chain;

    always_ff @(posedge clk or posedge mr_i) begin
        if (mr_i) chain <= '1;
        else      chain <= {chain[HOLD_N-2:0], 1'b0};
    end

    assign hold_o = chain[HOLD_N-1];

endmodule

// File: rtl/jdc_ring.sv
module jdc_ring #(
    parameter int unsigned W = jdc_pkg::RING_W_DEF
) (
    input  logic         clk,
    input  logic         mr_i,
    input  logic         hold_i,
    input  logic         seed_we_i,
    input  logic [W-1:0] seed_i,
    input  logic         adv_i,
    output logic [W-1:0] ring_o
);
    logic [W-1:0] ring_q;
    logic [W-1:0] ring_nx;

    // Twisted shift: stage 0 takes the inverted top stage, others shift up.
    assign ring_nx[0] = ~ring_q[W-1];

    for (genvar i = 1; i < W; i++) begin : g_shift
        if (i == 2) begin : g_steer
            // A lone one in stage 1 with zeros on both sides never occurs in
            // the legal cycle; dropping it folds the stray loops into it.
            assign ring_nx[i] = ring_q[1] & (ring_q[0] | ring_q[2]);
        end else begin : g_plain
            assign ring_nx[i] = ring_q[i-1];
        end
    end

    always_ff @(posedge clk or posedge mr_i) begin
        if (mr_i)           ring_q <= '0;
        else if (hold_i)    ring_q <= '0;
        else if (seed_we_i) ring_q <= seed_i;
        else if (adv_i)     ring_q <= ring_nx;
    end

    assign ring_o = ring_q;

endmodule

// File: rtl/jdc_decode.sv
module jdc_decode #(
    parameter int unsigned W = jdc_pkg::RING_W_DEF
) (
    input  logic [W-1:0]   ring_i,
    output logic [2*W-1:0] dec_o,
    output logic           carry_n_o
);
    // Each line looks at one pair of neighbouring stages; only one stage
    // changes per step, so no line can pulse between two counts.
    for (genvar k = 0; k < W; k++) begin : g_lo
        if (k == 0) begin : g_first
            assign dec_o[0] = ~ring_i[W-1] & ~ring_i[0];
        end else begin : g_mid
            assign dec_o[k] = ring_i[k-1] & ~ring_i[k];
        end
    end

    for (genvar k = 0; k < W; k++) begin : g_hi
        if (k == 0) begin : g_first
            assign dec_o[W] = ring_i[W-1] & ring_i[0];
        end else begin : g_mid
            assign dec_o[W+k] = ~ring_i[k-1] & ring_i[k];
        end
    end

    assign carry_n_o = ~ring_i[W-1];

endmodule

// File: rtl/jdc_counter.sv
module jdc_counter #(
    parameter int unsigned W      = jdc_pkg::RING_W_DEF,
    parameter int unsigned SYNC_N = jdc_pkg::SYNC_N_DEF,
    parameter int unsigned HOLD_N = jdc_pkg::HOLD_N_DEF
) (
    input  logic           clk,
    input  logic           mr_i,
    input  logic           tick_p_i,
    input  logic           tick_n_i,
    input  logic           seed_we_i,
    input  logic [W-1:0]   seed_i,
    output logic [2*W-1:0] dec_o,
    output logic           carry_n_o
);
    logic         adv;
    logic         hold;
    logic [W-1:0] ring;

    jdc_edge_sync #(.SYNC_N(SYNC_N)) u_sync (
        .clk      (clk),
        .tick_p_i (tick_p_i),
        .tick_n_i (tick_n_i),
        .adv_o    (adv)
    );

    jdc_rst_hold #(.HOLD_N(HOLD_N)) u_hold (
        .clk    (clk),
        .mr_i   (mr_i),
        .hold_o (hold)
    );

    jdc_ring #(.W(W)) u_ring (
        .clk       (clk),
        .mr_i      (mr_i),
        .hold_i    (hold),
        .seed_we_i (seed_we_i),
        .seed_i    (seed_i),
        .adv_i     (adv),
        .ring_o    (ring)
    );

    jdc_decode #(.W(W)) u_dec (
        .ring_i    (ring),
        .dec_o     (dec_o),
        .carry_n_o (carry_n_o)
    );

endmodule

// File: rtl/jdc_counter_chk.sv
module jdc_counter_chk #(
    parameter int unsigned W = jdc_pkg::RING_W_DEF
) (
    input logic           clk,
    input logic           mr_i,
    input logic           tick_p_i,
    input logic           tick_n_i,
    input logic           seed_we_i,
    input logic [2*W-1:0] dec_o,
    input logic           carry_n_o
);
    localparam int unsigned N = 2 * W;

    AST_CLEAR_STATE: assert property (@(posedge clk)
        mr_i |-> (dec_o == {{(N-1){1'b0}}, 1'b1}) && carry_n_o); // R1

    AST_QUIET_INPUTS: assert property (@(posedge clk) disable iff (mr_i)
        ($past(tick_p_i, 1) == $past(tick_p_i, 2) && $past(tick_p_i, 2) == $past(tick_p_i, 3) &&
         $past(tick_p_i, 3) == $past(tick_p_i, 4) &&
         $past(tick_n_i, 1) == $past(tick_n_i, 2) && $past(tick_n_i, 2) == $past(tick_n_i, 3) &&
         $past(tick_n_i, 3) == $past(tick_n_i, 4) && !$past(seed_we_i))
        |-> $stable(dec_o)); // R4

    AST_STEP_ORDER: assert property (@(posedge clk) disable iff (mr_i)
        ($onehot($past(dec_o)) && !$past(seed_we_i) && !$past(mr_i))
        |-> (dec_o == $past(dec_o)) || (dec_o == {$past(dec_o[N-2:0]), $past(dec_o[N-1])})); // R5

    AST_CARRY_HALF: assert property (@(posedge clk) disable iff (mr_i)
        $onehot(dec_o) |-> (carry_n_o == ~|dec_o[N-1:W])); // R6

endmodule

bind jdc_counter jdc_counter_chk #(.W(W)) u_chk (.*);

// File: tb/jdc_counter_tb.sv
module jdc_counter_tb;

    logic       clk = 1'b0;
    logic       mr_i = 1'b1;
    logic       tick_p_i = 1'b0;
    logic       tick_n_i = 1'b0;
    logic       seed_we_i = 1'b0;
    logic [4:0] seed_i = '0;
    logic [9:0] dec_o;
    logic       carry_n_o;

    int n_chk  = 0;
    int n_fail = 0;
    int idx    = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    jdc_counter u_dut (
        .clk       (clk),
        .mr_i      (mr_i),
        .tick_p_i  (tick_p_i),
        .tick_n_i  (tick_n_i),
        .seed_we_i (seed_we_i),
        .seed_i    (seed_i),
        .dec_o     (dec_o),
        .carry_n_o (carry_n_o)
    );

    function automatic logic [4:0] legal_code(input int k);
        if (k < 5) return 5'((1 << k) - 1);
        return 5'(31 & ~((1 << (k - 5)) - 1));
    endfunction

    function automatic bit is_legal(input logic [4:0] c);
        for (int k = 0; k < 10; k++) if (legal_code(k) == c) return 1'b1;
        return 1'b0;
    endfunction

    function automatic int hot_index(input logic [9:0] d);
        for (int k = 0; k < 10; k++) if (d[k]) return k;
        return -1;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [9:0] act, input logic [9:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic chk_count(input string req, input int k);
        chk(dec_o == (10'd1 << k), req, dec_o, 10'd1 << k);
        chk(carry_n_o == (k < 5), {req, " carry R6"}, {9'd0, carry_n_o}, {9'd0, 1'(k < 5)});
    endtask

    task automatic wait_neg(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_p;
        tick_p_i = 1'b1;
        wait_neg(4);
        tick_p_i = 1'b0;
        wait_neg(4);
    endtask

    task automatic seed(input logic [4:0] v);
        seed_i    = v;
        seed_we_i = 1'b1;
        wait_neg(1);
        seed_we_i = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        wait_neg(3);
        chk_count("R1 clear state", 0);
        mr_i = 1'b0;
        wait_neg(4);

        // R9: rising edge placed on a falling clock edge, watch the third rising edge
        tick_p_i = 1'b1;
        wait_neg(2);
        chk(dec_o == 10'd1, "R9 unchanged after two edges", dec_o, 10'd1);
        wait_neg(1);
        chk(dec_o == 10'd2, "R9 changed after third edge", dec_o, 10'd2);
        tick_p_i = 1'b0;
        wait_neg(4);
        idx = 1;

        // R2, R5, R6: long train of rising edges with tick_n low
        for (int i = 0; i < 22; i++) begin
            pulse_p();
            idx = (idx + 1) % 10;
            chk_count("R2 R5 rise advance", idx);
        end

        // R3 with R4: gating input moves first
        for (int i = 0; i < 12; i++) begin
            tick_n_i = 1'b1;
            wait_neg(4);
            chk_count("R4 tick_n rise ignored", idx);
            tick_p_i = 1'b1;
            wait_neg(4);
            chk_count("R4 rise while tick_n high ignored", idx);
            tick_n_i = 1'b0;
            wait_neg(4);
            idx = (idx + 1) % 10;
            chk_count("R3 fall while tick_p high advances", idx);
            tick_p_i = 1'b0;
            wait_neg(4);
            chk_count("R4 tick_p fall ignored", idx);
        end

        // R4: falling edge of tick_n while tick_p low
        tick_n_i = 1'b1;
        wait_neg(4);
        tick_n_i = 1'b0;
        wait_neg(4);
        chk_count("R4 fall while tick_p low ignored", idx);

        // R1: clear raised between clock edges acts before the next rising edge
        wait_neg(1);
        mr_i = 1'b1;
        #2;
        chk(dec_o == 10'd1, "R1 asynchronous clear", dec_o, 10'd1);
        wait_neg(2);
        mr_i = 1'b0;
        wait_neg(4);
        idx = 0;

        // R8: seed every legal code
        for (int k = 9; k >= 0; k--) begin
            seed(legal_code(k));
            chk_count("R8 seed legal code", k);
        end

        // R7: every illegal pattern recovers within 11 advances
        for (int c = 0; c < 32; c++) begin
            if (!is_legal(5'(c))) begin
                int j;
                seed(5'(c));
                for (int s = 0; s < 11; s++) pulse_p();
                chk($onehot(dec_o), "R7 legal after 11 advances", dec_o, 10'd1 << hot_index(dec_o));
                j = hot_index(dec_o);
                for (int s = 0; s < 10; s++) begin
                    pulse_p();
                    if (j >= 0) j = (j + 1) % 10;
                    chk(j >= 0 && dec_o == (10'd1 << j), "R7 order after recovery",
                        dec_o, (j >= 0) ? (10'd1 << j) : 10'd0);
                end
            end
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule